// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Controller with Edge Interrupts

This block drives and samples eight bidirectional pads from a byte-wide register interface. Each pin has a bit in five registers. The direction register makes the pin an input or an output. The inversion register flips the sampled level. The level register holds the driven value. The three-state register turns the pad driver off. The interrupt-enable register arms the pin. Register bit n always belongs to pin n.

Each pad input passes through a two-flop synchroniser and then the optional inversion. A rising edge on the inverted signal of an armed input pin sets a pending flag. With inversion, a pin can therefore interrupt on a falling pad edge. The single interrupt output is the OR of all pending flags. A read of the level register clears every flag as a side effect. An edge that lands in the same cycle as that read still leaves its flag set.

Software typically writes the direction, three-state and level registers for the outputs and sets inversion and enables for the inputs. It then services the interrupt by reading the level register, which both returns the pin states and acknowledges the interrupt.

Top module: `gpio8_ctrl`

## Requirements
- R1: After reset, direction (address 0) reads 0xFF and inversion (address 1), three-state (address 3) and interrupt enable (address 4) read 0x00. pad_out and pad_oe are 0x00 and irq is 0.
- R2: pad_out equals the value last written to the level register (address 2). pad_oe bit n is 1 only when direction bit n is 0 (output) and three-state bit n is 0.
- R3: A three-state bit of 1 forces pad_oe low for that pin even when the pin is an output. pad_out keeps the level value.
- R4: Reading address 2 returns, for input pins, the synchronised pad level XOR the inversion bit, and for output pins the written level bit. rdata is valid combinationally while rd_en is high.
- R5: For an input pin with its enable set, a rising pad edge driven before clock edge k raises irq after clock edge k+2 and not before.
- R6: With the inversion bit set, a falling pad edge on an enabled input raises irq, and a rising pad edge does not.
- R7: Output pins, and input pins whose enable bit is 0, never set a pending flag, whatever their pads do.
- R8: A read of address 2 clears all pending flags, so irq is low after that clock edge.
- R9: A qualifying edge that sets a flag in the same cycle as a level-register read keeps that flag set, and irq stays high.
- R10: Addresses 5 to 7 read as 0x00, and writes to them change no register.
- R11: Direction, inversion, three-state and interrupt-enable registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; a read of address 2 clears pending flags |
| rdata | output | 8 | Read data, zero when rd_en is low |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad driver enables, 1 drives |
| irq | output | 1 | Interrupt, OR of pending flags |

## Verification
The hardest case to reach from the ports is a qualifying edge that reaches the pending logic in the same clock cycle as an acknowledging read. The synchroniser delay hides the edge from the bus side, so the stimulus counts clock edges from the pad change. It raises rd_en on address 2 exactly in the cycle before the flag would set. It then checks that irq is still high, and that a second read clears it. The inverted-polarity path is reached by first arming inversion while the pad is high, which must not interrupt, and then dropping the pad.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;
   localparam int unsigned REG_DIR = 0;
   localparam int unsigned REG_INV = 1;
   localparam int unsigned REG_LVL = 2;
   localparam int unsigned REG_TRI = 3;
   localparam int unsigned REG_IEN = 4;
   localparam int unsigned REG_COUNT = 5;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_LVL  = 2'd2
   } rd_sel_e;
endpackage

// File: rtl/gpio8_regs.sv
module gpio8_regs #(
   parameter int unsigned NPINS = 8,
   parameter int unsigned AW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   input  logic [NPINS-1:0] wdata,
   input  logic             wr_en,
   output logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] inv_q,
   output logic [NPINS-1:0] lvl_q,
   output logic [NPINS-1:0] tri_q,
   output logic [NPINS-1:0] ien_q
);
   import gpio8_pkg::*;

   localparam logic [AW-1:0] A_DIR = AW'(REG_DIR);
   localparam logic [AW-1:0] A_INV = AW'(REG_INV);
   localparam logic [AW-1:0] A_LVL = AW'(REG_LVL);
   localparam logic [AW-1:0] A_TRI = AW'(REG_TRI);
   localparam logic [AW-1:0] A_IEN = AW'(REG_IEN);

   if ((1 << AW) < REG_COUNT) begin : g_aw_check
      $error("gpio8_regs: address width too small for register count");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '1;
         inv_q <= '0;
         lvl_q <= '0;
         tri_q <= '0;
         ien_q <= '0;
      end else if (wr_en) begin
         case (addr)
            A_DIR:   dir_q <= wdata;
            A_INV:   inv_q <= wdata;
            A_LVL:   lvl_q <= wdata;
            A_TRI:   tri_q <= wdata;
            A_IEN:   ien_q <= wdata;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
   parameter int unsigned NPINS  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] d_async,
   output logic [NPINS-1:0] d_sync
);
   if (STAGES < 2) begin : g_stage_check
      $error("gpio8_sync: at least two stages required");
   end

   logic [NPINS-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d_async;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio8_edge.sv
module gpio8_edge #(
   parameter int unsigned NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] cond,
   input  logic [NPINS-1:0] arm,
   input  logic             clr,
   output logic [NPINS-1:0] rise,
   output logic [NPINS-1:0] pend
);
   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic prev_q;
      logic flag_q;

      assign rise[i] = cond[i] & ~prev_q & arm[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
         end else begin
            prev_q <= cond[i];
            // a new edge wins over the acknowledge
            flag_q <= rise[i] | (flag_q & ~clr);
         end
      end

      assign pend[i] = flag_q;
   end
endmodule

// File: rtl/gpio8_ctrl.sv
module gpio8_ctrl #(
   parameter int unsigned NPINS       = 8,
   parameter int unsigned AW          = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   input  logic [NPINS-1:0] wdata,
   input  logic             wr_en,
   input  logic             rd_en,
   output logic [NPINS-1:0] rdata,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe,
   output logic             irq
);
   import gpio8_pkg::*;

   if (NPINS < 1 || NPINS > 32) begin : g_width_check
      $error("gpio8_ctrl: NPINS out of range");
   end

   localparam logic [AW-1:0] A_LVL = AW'(REG_LVL);

   logic [NPINS-1:0] dir_q, inv_q, lvl_q, tri_q, ien_q;
   logic [NPINS-1:0] pin_sync, pin_cond, rise, pend;
   logic             ack;
   rd_sel_e          sel;

   gpio8_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .dir_q(dir_q), .inv_q(inv_q), .lvl_q(lvl_q), .tri_q(tri_q), .ien_q(ien_q)
   );

   gpio8_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(pad_in), .d_sync(pin_sync)
   );

   assign pin_cond = pin_sync ^ inv_q;
   assign ack      = rd_en && (addr == A_LVL);

   gpio8_edge #(.NPINS(NPINS)) u_edge (
      .clk(clk), .rst_n(rst_n), .cond(pin_cond), .arm(dir_q & ien_q),
      .clr(ack), .rise(rise), .pend(pend)
   );

   assign pad_out = lvl_q;
   assign pad_oe  = ~dir_q & ~tri_q;
   assign irq     = |pend;

   always_comb begin
      if (!rd_en || int'(addr) >= REG_COUNT) sel = SEL_NONE;
      else if (addr == A_LVL)                sel = SEL_LVL;
      else                                   sel = SEL_CTRL;
   end

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_LVL: rdata = (dir_q & pin_cond) | (~dir_q & lvl_q);
         SEL_CTRL: begin
            case (int'(addr))
               REG_DIR: rdata = dir_q;
               REG_INV: rdata = inv_q;
               REG_TRI: rdata = tri_q;
               REG_IEN: rdata = ien_q;
               default: rdata = '0;
            endcase
         end
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio8_ctrl_chk.sv
module gpio8_ctrl_chk #(
   parameter int unsigned NPINS = 8,
   parameter int unsigned AW    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [AW-1:0]    addr,
   input logic             rd_en,
   input logic [NPINS-1:0] rdata,
   input logic [NPINS-1:0] pad_oe,
   input logic             irq,
   input logic [NPINS-1:0] dir_q,
   input logic [NPINS-1:0] tri_q,
   input logic [NPINS-1:0] ien_q,
   input logic [NPINS-1:0] rise,
   input logic [NPINS-1:0] pend
);
   logic ack_c;
   assign ack_c = rd_en && (int'(addr) == 2);

   p_tri_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tri_q & pad_oe) == '0);

   p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(rise) != '0);

   p_arm_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~$past(pend)) & ~$past(dir_q & ien_q)) == '0);

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_c && rise == '0) |=> pend == '0);

   p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_c) |=> (pend & $past(pend)) == $past(pend));

   p_undef_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && int'(addr) >= 5) |-> rdata == '0);
endmodule

bind gpio8_ctrl gpio8_ctrl_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .rdata(rdata),
   .pad_oe(pad_oe), .irq(irq), .dir_q(dir_q), .tri_q(tri_q), .ien_q(ien_q),
   .rise(rise), .pend(pend)
);

// File: tb/tb_gpio8_ctrl.sv
module tb_gpio8_ctrl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rdata;
   logic [7:0] pad_in = '0;
   logic [7:0] pad_out;
   logic [7:0] pad_oe;
   logic       irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   gpio8_ctrl dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] v;
      check("R1 pad_out", pad_out, 8'h00);
      check("R1 pad_oe", pad_oe, 8'h00);
      check("R1 irq", {7'd0, irq}, 8'h00);
      rd(3'd0, v); check("R1 dir", v, 8'hFF);
      rd(3'd1, v); check("R1 inv", v, 8'h00);
      rd(3'd3, v); check("R1 tri", v, 8'h00);
      rd(3'd4, v); check("R1 ien", v, 8'h00);
   endtask

   task automatic t_regs;
      logic [7:0] v;
      wr(3'd1, 8'h5A); rd(3'd1, v); check("R11 inv readback", v, 8'h5A);
      wr(3'd4, 8'hC3); rd(3'd4, v); check("R11 ien readback", v, 8'hC3);
      wr(3'd1, 8'h00); wr(3'd4, 8'h00);
   endtask

   task automatic t_pads;
      wr(3'd0, 8'h0F);
      wr(3'd2, 8'hA5);
      check("R2 pad_out", pad_out, 8'hA5);
      check("R2 pad_oe", pad_oe, 8'hF0);
   endtask

   task automatic t_tristate;
      wr(3'd3, 8'h30);
      check("R3 pad_oe", pad_oe, 8'hC0);
      check("R3 pad_out kept", pad_out, 8'hA5);
   endtask

   task automatic t_level_read;
      logic [7:0] v;
      pad_in = 8'hFC;
      wr(3'd1, 8'h01);
      idle(3);
      rd(3'd2, v); check("R4 level read", v, 8'hAD);
      wr(3'd1, 8'h00);
   endtask

   task automatic t_rise;
      logic [7:0] v;
      wr(3'd4, 8'h0F);
      rd(3'd2, v);
      check("R5 idle irq", {7'd0, irq}, 8'h00);
      @(negedge clk); pad_in = 8'h0E;      // before edge k
      @(negedge clk);                      // after k
      check("R5 irq after k", {7'd0, irq}, 8'h00);
      @(negedge clk);                      // after k+1
      check("R5 irq after k+1", {7'd0, irq}, 8'h00);
      @(negedge clk);                      // after k+2
      check("R5 irq after k+2", {7'd0, irq}, 8'h01);
   endtask

   task automatic t_clear;
      logic [7:0] v;
      rd(3'd2, v);
      check("R8 level value", v, 8'hAE);
      check("R8 irq cleared", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_inverted;
      logic [7:0] v;
      wr(3'd1, 8'h04);
      idle(4);
      check("R6 no irq on inversion arm", {7'd0, irq}, 8'h00);
      pad_in = 8'h0A;
      idle(4);
      check("R6 falling edge irq", {7'd0, irq}, 8'h01);
      rd(3'd2, v);
      pad_in = 8'h0E;
      idle(4);
      check("R6 rising pad ignored", {7'd0, irq}, 8'h00);
      wr(3'd1, 8'h00);
      idle(4);
      rd(3'd2, v);
   endtask

   task automatic t_noirq;
      logic [7:0] v;
      wr(3'd4, 8'hFE);
      pad_in = 8'h0A;
      idle(4);
      rd(3'd2, v);
      pad_in = 8'hFB;                      // pins 7..4 outputs, pin 0 disabled
      idle(5);
      check("R7 no irq from outputs or disabled", {7'd0, irq}, 8'h00);
      pad_in = 8'h09;
      idle(4);
      rd(3'd2, v);
   endtask

   task automatic t_coincide;
      logic [7:0] v;
      @(negedge clk); pad_in = 8'h0B;      // before edge k
      @(negedge clk);                      // after k
      @(negedge clk);                      // after k+1
      addr = 3'd2; rd_en = 1'b1;           // read hits edge k+2
      @(negedge clk);
      rd_en = 1'b0;
      check("R9 edge with read keeps irq", {7'd0, irq}, 8'h01);
      rd(3'd2, v);
      check("R9 second read clears", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_undef;
      logic [7:0] v;
      wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
      rd(3'd5, v); check("R10 addr5 zero", v, 8'h00);
      rd(3'd7, v); check("R10 addr7 zero", v, 8'h00);
      rd(3'd0, v); check("R10 dir unchanged", v, 8'h0F);
      rd(3'd3, v); check("R10 tri unchanged", v, 8'h30);
      rd(3'd4, v); check("R10 ien unchanged", v, 8'hFE);
      check("R10 pad_out unchanged", pad_out, 8'hA5);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_pads();
      t_tristate();
      t_level_read();
      t_rise();
      t_clear();
      t_inverted();
      t_noirq();
      t_coincide();
      t_undef();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule